// File: doc/BRIEF.md
# Configurable Quasi-Bidirectional Port Controller

An 8-bit general-purpose I/O port controller for a small microcontroller. Each pin has an output data latch bit and a two-bit output mode. The mode is formed from bit n of configuration register A and bit n of configuration register B. For each pin the block drives three digital driver enables: a strong pull-up, a weak pull-up and a pull-down. The analog pad turns these enables into drive.

The strong pull-up in quasi-bidirectional mode is a one-shot pulse. It fires when the pin's effective output rises, and after it ends only the weak pull-up holds the line high. An alternate-function output reaches a pin only through the AND with that pin's latch bit. Two designated pins are restricted so that they can only be open-drain or high-impedance, which keeps them safe for an I2C bus. A parameter removes this restriction for ports without such pins.

Software accesses the port through a small register interface. It supports whole-byte and single-bit writes and combinational reads. A separate pin-read strobe returns the pad levels after a two-flop synchroniser.

Top module: `qport_ctrl`

## Requirements
- R1: After reset the data latch reads 0xFF, configuration B reads 0x00 and configuration A reads 0x3F with the I2C restriction on bits 6 and 7 (0xFF without it). Ordinary pins drive only the weak pull-up and the restricted pins drive nothing.
- R2: Register select 0 addresses the data latch, 1 addresses configuration A and 2 addresses configuration B. A byte write replaces the selected register and a read returns its contents. Select 3 is reserved: writes to it change nothing and it reads 0x00.
- R3: When the bit-mode input is high, a write changes only the register bit given by the bit index, setting it to wdata bit 0.
- R4: A pin's mode is {A,B} = {cfga[n], cfgb[n]}. In open-drain mode ({0,0}) the pin's pull-down equals the inverse of its effective output, and neither pull-up is enabled.
- R5: In quasi-bidirectional mode ({1,0}) the pull-down is on while the effective output is 0 and the weak pull-up is on while it is 1. A 0-to-1 rise of the effective output turns on the strong pull-up from the moment of the rise until the second clock edge after it.
- R6: In high-impedance mode ({0,1}) all three enables are off.
- R7: In push-pull mode ({1,1}) the strong pull-up is on while the effective output is 1 and the pull-down is on while it is 0. The weak pull-up is off. A pull-up and the pull-down are never on together in any mode.
- R8: With the restriction enabled, pins 6 and 7 treat the quasi-bidirectional and push-pull encodings as open-drain and never enable either pull-up.
- R9: A pin's effective output is its latch bit ANDed with its alternate-function input. A rise of the alternate input while the latch is 1 starts the strong pulse in quasi-bidirectional mode.
- R10: While pin_rd_i is high, rdata_o returns the pin levels seen two clock edges earlier.
- R11: A configuration write takes effect at the clock edge that performs it. A mode change with the latch already at 1 starts no strong pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| bit_mode_i | input | 1 | Write a single bit instead of a byte |
| sel_i | input | 2 | Register select: 0 data, 1 config A, 2 config B, 3 reserved |
| bit_idx_i | input | 3 | Bit index for single-bit writes |
| wdata_i | input | 8 | Write data (bit 0 in bit mode) |
| pin_rd_i | input | 1 | Read synchronised pin levels instead of a register |
| rdata_o | output | 8 | Read data |
| alt_i | input | 8 | Alternate-function outputs, tie to 1 when unused |
| pin_i | input | 8 | Sampled pad levels |
| pu_strong_o | output | 8 | Strong pull-up enables |
| pu_weak_o | output | 8 | Weak pull-up enables |
| pd_o | output | 8 | Pull-down enables |

## Verification
All four mode encodings are applied to an ordinary pin and a restricted pin at the same time, each with latch and alternate input set to (1,1), (0,1) and (1,0). These combinations separate the modes by their pull-up behaviour and show that either gating input alone forces a low. They also show that the restricted pin folds quasi-bidirectional and push-pull into open-drain. Directed sequences measure the strong pulse width for a rise from a latch write and for a rise from an alternate input. A further sequence shows that a mode change with the latch already high starts no pulse. Single-bit writes, reserved-address writes and the synchroniser delay are checked through the read port.

// File: rtl/qport_pkg.sv
package qport_pkg;
  // encoding is {cfga bit, cfgb bit}
  typedef enum logic [1:0] {
    MODE_OD = 2'b00,
    MODE_HZ = 2'b01,
    MODE_QB = 2'b10,
    MODE_PP = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CFGA = 2'd1,
    SEL_CFGB = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/qport_regs.sv
module qport_regs
  import qport_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] RST_CFGA = '1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     bit_mode_i,
  input  logic [1:0]               sel_i,
  input  logic [$clog2(WIDTH)-1:0] bit_idx_i,
  input  logic [WIDTH-1:0]         wdata_i,
  output logic [WIDTH-1:0]         data_o,
  output logic [WIDTH-1:0]         cfga_o,
  output logic [WIDTH-1:0]         cfgb_o
);
  logic [WIDTH-1:0] mask, nval;

  always_comb begin
    mask = bit_mode_i ? (WIDTH'(1) << bit_idx_i) : '1;
    nval = bit_mode_i ? {WIDTH{wdata_i[0]}} : wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '1;
      cfga_o <= RST_CFGA;
      cfgb_o <= '0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(sel_i))
        SEL_DATA: data_o <= (data_o & ~mask) | (nval & mask);
        SEL_CFGA: cfga_o <= (cfga_o & ~mask) | (nval & mask);
        SEL_CFGB: cfgb_o <= (cfgb_o & ~mask) | (nval & mask);
        default: ;
      endcase
    end
  end

  a_r2_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_RSVD) |=> ($stable(data_o) && $stable(cfga_o) && $stable(cfgb_o)));

  a_r3_bit_write_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bit_mode_i && sel_i == SEL_DATA) |=> $countones(data_o ^ $past(data_o)) <= 1);
endmodule

// File: rtl/qport_sync.sv
module qport_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/qport_pin.sv
module qport_pin
  import qport_pkg::*;
#(
  parameter int PULSE_CYC = 2,
  parameter bit RESTRICT  = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      latch_i,
  input  logic      alt_i,
  input  pin_mode_e mode_i,
  output logic      strong_o,
  output logic      weak_o,
  output logic      pd_o
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic          drv, drv_q, rise, pulse;
  logic [CW-1:0] cnt;
  pin_mode_e     eff;

  assign drv   = latch_i & alt_i;
  assign rise  = drv & ~drv_q;
  assign pulse = rise | (cnt != '0);

  // pulse timer runs in every mode so a rise is tracked across mode writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q <= 1'b1;
      cnt   <= '0;
    end else begin
      drv_q <= drv;
      if (rise)            cnt <= CW'(PULSE_CYC - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  generate
    if (RESTRICT) begin : g_restrict
      assign eff = (mode_i == MODE_HZ) ? MODE_HZ : MODE_OD;
    end else begin : g_free
      assign eff = mode_i;
    end
  endgenerate

  always_comb begin
    strong_o = 1'b0;
    weak_o   = 1'b0;
    pd_o     = 1'b0;
    case (eff)
      MODE_OD: pd_o = ~drv;
      MODE_QB: begin
        pd_o     = ~drv;
        weak_o   = drv;
        strong_o = drv & pulse;
      end
      MODE_PP: begin
        pd_o     = ~drv;
        strong_o = drv;
      end
      default: ;
    endcase
  end

  // checker: length of a strong run in quasi-bidirectional mode
  logic [CW:0] run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           run <= '0;
    else if (strong_o && eff == MODE_QB)   run <= run + 1'b1;
    else                                   run <= '0;
  end

  a_r5_pulse_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run <= (CW+1)'(PULSE_CYC));

  a_r6_hz_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HZ) |-> (!strong_o && !weak_o && !pd_o));

  a_r7_no_fight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pd_o && (strong_o || weak_o)));

  a_r4_od_no_pullup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OD) |-> (!strong_o && !weak_o));

  generate
    if (RESTRICT) begin : g_chk
      a_r8_never_pulls_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(strong_o || weak_o));
    end
  endgenerate
endmodule

// File: rtl/qport_ctrl.sv
module qport_ctrl
  import qport_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter int               PULSE_CYC = 2,
  parameter bit               I2C_EN    = 1'b1,
  parameter logic [WIDTH-1:0] I2C_PINS  = 'hC0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     bit_mode_i,
  input  logic [1:0]               sel_i,
  input  logic [$clog2(WIDTH)-1:0] bit_idx_i,
  input  logic [WIDTH-1:0]         wdata_i,
  input  logic                     pin_rd_i,
  output logic [WIDTH-1:0]         rdata_o,
  input  logic [WIDTH-1:0]         alt_i,
  input  logic [WIDTH-1:0]         pin_i,
  output logic [WIDTH-1:0]         pu_strong_o,
  output logic [WIDTH-1:0]         pu_weak_o,
  output logic [WIDTH-1:0]         pd_o
);
  localparam logic [WIDTH-1:0] RMASK    = I2C_EN ? I2C_PINS : '0;
  localparam logic [WIDTH-1:0] RST_CFGA = ~RMASK;

  logic [WIDTH-1:0] data_q, cfga_q, cfgb_q, pin_s;

  qport_regs #(.WIDTH(WIDTH), .RST_CFGA(RST_CFGA)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .bit_mode_i, .sel_i, .bit_idx_i, .wdata_i,
    .data_o(data_q), .cfga_o(cfga_q), .cfgb_o(cfgb_q)
  );

  qport_sync #(.WIDTH(WIDTH)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    qport_pin #(.PULSE_CYC(PULSE_CYC), .RESTRICT(RMASK[n])) i_pin (
      .clk_i, .rst_ni,
      .latch_i (data_q[n]),
      .alt_i   (alt_i[n]),
      .mode_i  (pin_mode_e'({cfga_q[n], cfgb_q[n]})),
      .strong_o(pu_strong_o[n]),
      .weak_o  (pu_weak_o[n]),
      .pd_o    (pd_o[n])
    );
  end

  always_comb begin
    if (pin_rd_i) rdata_o = pin_s;
    else begin
      case (reg_sel_e'(sel_i))
        SEL_DATA: rdata_o = data_q;
        SEL_CFGA: rdata_o = cfga_q;
        SEL_CFGB: rdata_o = cfgb_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: tb/test_qport_ctrl.sv
`timescale 1ns/1ps
module test_qport_ctrl;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en = 0, bit_mode = 0, pin_rd = 0;
  logic [1:0] sel = 0;
  logic [2:0] bit_idx = 0;
  logic [7:0] wdata = 0, alt = 8'hFF, pin = 0;
  logic [7:0] rdata, ps, pw, pd;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  qport_ctrl i_qport_ctrl (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .bit_mode_i(bit_mode), .sel_i(sel),
    .bit_idx_i(bit_idx), .wdata_i(wdata), .pin_rd_i(pin_rd), .rdata_o(rdata),
    .alt_i(alt), .pin_i(pin), .pu_strong_o(ps), .pu_weak_o(pw), .pd_o(pd)
  );

  // {a, b, latch, alt, pin0 {strong,weak,pd}, pin6 {strong,weak,pd}}
  localparam logic [9:0] VEC [12] = '{
    10'b00_11_000_000, 10'b00_01_001_001, 10'b00_10_001_001,
    10'b10_11_010_000, 10'b10_01_001_001, 10'b10_10_001_001,
    10'b01_11_000_000, 10'b01_01_000_000, 10'b01_10_000_000,
    10'b11_11_100_000, 10'b11_01_001_001, 10'b11_10_001_001
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic bm, input logic [2:0] idx, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; sel = s; bit_mode = bm; bit_idx = idx; wdata = v;
    @(negedge clk);
    wr_en = 0; bit_mode = 0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] s, input logic [7:0] exp);
    sel = s; pin_rd = 0; #1;
    check(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    rd_check("R1 data", 2'd0, 8'hFF);
    rd_check("R1 cfga", 2'd1, 8'h3F);
    rd_check("R1 cfgb", 2'd2, 8'h00);
    check("R1 weak", pw, 8'h3F);
    check("R1 strong+pd", ps | pd, 8'h00);

    // table: R4 R5 R6 R7 R8 R9 steady state, pin 0 vs restricted pin 6
    foreach (VEC[i]) begin
      wr(2'd1, 0, 0, {8{VEC[i][9]}});
      wr(2'd2, 0, 0, {8{VEC[i][8]}});
      alt = {8{VEC[i][6]}};
      wr(2'd0, 0, 0, {8{VEC[i][7]}});
      repeat (3) @(negedge clk);
      check($sformatf("R4-7/R9 vec%0d pin0", i), {5'd0, ps[0], pw[0], pd[0]}, {5'd0, VEC[i][5:3]});
      check($sformatf("R8 vec%0d pin6", i), {5'd0, ps[6], pw[6], pd[6]}, {5'd0, VEC[i][2:0]});
    end

    // R5 strong pulse after latch rise
    alt = 8'hFF;
    wr(2'd1, 0, 0, 8'hFF);
    wr(2'd2, 0, 0, 8'h00);
    wr(2'd0, 0, 0, 8'h00);
    wr(2'd0, 0, 0, 8'hFF);
    check("R5 pulse c1", ps, 8'h3F);
    @(negedge clk); check("R5 pulse c2", ps, 8'h3F);
    @(negedge clk); check("R5 pulse end", ps, 8'h00);
    check("R5 weak hold", pw, 8'h3F);

    // R9 alternate rise with latch 1
    alt = 8'h00; repeat (2) @(negedge clk);
    check("R9 alt low pd", pd, 8'hFF);
    alt = 8'h01; #1;
    check("R9 alt rise strong", ps, 8'h01);
    @(negedge clk); check("R9 alt pulse c2", ps, 8'h01);
    @(negedge clk); check("R9 alt pulse end", ps, 8'h00);
    alt = 8'hFF; repeat (3) @(negedge clk);

    // R11 mode change timing, no pulse with latch already 1
    wr(2'd1, 1, 3'd1, 8'h00);
    check("R11 od off", {7'd0, pw[1]}, 8'h00);
    @(negedge clk);
    wr_en = 1; sel = 2'd1; bit_mode = 1; bit_idx = 3'd1; wdata = 8'h01; #1;
    check("R11 before edge", {7'd0, pw[1]}, 8'h00);
    @(negedge clk); wr_en = 0; bit_mode = 0;
    check("R11 after edge", {6'd0, pw[1], ps[1]}, 8'h02);

    // R3 bit write
    wr(2'd0, 0, 0, 8'h00);
    wr(2'd0, 1, 3'd5, 8'h01);
    rd_check("R3 bit set", 2'd0, 8'h20);
    wr(2'd2, 1, 3'd2, 8'hFE);
    rd_check("R3 bit clear keeps others", 2'd2, 8'h00);

    // R2 byte write/read and reserved address
    wr(2'd2, 0, 0, 8'h5A);
    rd_check("R2 cfgb", 2'd2, 8'h5A);
    wr(2'd3, 0, 0, 8'h55);
    rd_check("R2 rsvd data", 2'd0, 8'h20);
    rd_check("R2 rsvd cfga", 2'd1, 8'hFF);
    rd_check("R2 rsvd cfgb", 2'd2, 8'h5A);
    rd_check("R2 rsvd read", 2'd3, 8'h00);

    // R10 synchronised pin read
    @(negedge clk);
    pin = 8'hA5; pin_rd = 1;
    @(negedge clk); check("R10 one edge", rdata, 8'h00);
    @(negedge clk); check("R10 two edges", rdata, 8'hA5);
    pin_rd = 0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule